// File: doc/BRIEF.md
# Field-Addressed Condition Register Unit

This block keeps a condition register built from eight independent 4-bit fields. It also keeps the sticky summary-overflow bit that those fields copy. Three update sources write fields. A record update compares an integer result with zero and writes field 0. A compare update checks two operands, signed or unsigned, and writes any field chosen by an index. A conditional-store update writes field 0 from the store's success flag. Every write also copies the summary-overflow bit into the field. The whole register is always visible on one output. Any single field can be read through a selectable read port.

Each update channel is a valid strobe with its operands. There is no ready signal because the unit takes one update of each kind in every cycle and never applies back-pressure. The upstream stage may assert any mix of the three valids in the same cycle. Fixed priority rules decide which one wins field 0. All control and read pins are plain signals.

Top module: `cr_unit`

## Requirements
- R1: After reset every field reads 0 and the summary-overflow bit `so_out` reads 0.
- R2: Each field is a 4-bit nibble with bit 0 = less-than, bit 1 = greater-than, bit 2 = equal, bit 3 = summary overflow. Field k sits at `cr_out[4k+3:4k]`.
- R3: A record update (`rec_valid`) treats `rec_result` as a signed 32-bit value compared with zero. It writes field 0 with exactly one of less-than, greater-than or equal set.
- R4: A compare update (`cmp_valid`) writes the field named by `cmp_field`. It compares `cmp_a` with `cmp_b` as signed values when `cmp_signed` is 1 and as unsigned values when it is 0. Exactly one of less-than, greater-than or equal is set.
- R5: A conditional-store update (`stc_valid`) writes field 0. Equal is set to `stc_success`, and less-than and greater-than are cleared.
- R6: The summary-overflow bit is sticky. It is set by `ov_in` and cleared only by `so_clear`. When both are high in the same cycle, `ov_in` wins.
- R7: Bit 3 of any field written in a cycle receives the summary-overflow value that results from that same cycle's `ov_in` and `so_clear`.
- R8: On field 0 a compare has priority over a conditional store, and a conditional store has priority over a record update. A compare aimed at another field and a record update in the same cycle both take effect.
- R9: A field not targeted by any valid update keeps its value. Operands presented while their valid is low have no effect.
- R10: `rd_field` shows the field selected by `rd_sel` with no clock delay. An update becomes visible on the outputs one clock after its valid is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record update strobe for field 0 |
| rec_result | input | 32 | Integer result to classify against zero |
| cmp_valid | input | 1 | Compare update strobe |
| cmp_signed | input | 1 | 1 = signed compare, 0 = unsigned |
| cmp_field | input | 3 | Destination field index for the compare |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| stc_valid | input | 1 | Conditional-store outcome strobe |
| stc_success | input | 1 | 1 when the conditional store succeeded |
| ov_in | input | 1 | Overflow seen by this cycle's arithmetic |
| so_clear | input | 1 | Explicit clear of summary overflow |
| rd_sel | input | 3 | Field index for the read port |
| rd_field | output | 4 | Selected field |
| cr_out | output | 32 | Whole condition register |
| so_out | output | 1 | Sticky summary-overflow bit |

## Verification
Record results are tried at positive, zero and the most negative value. These cases separate a signed sign test from a plain nonzero test. Compares use operand pairs whose order flips between signed and unsigned interpretation (all-ones against one, and the largest positive against the most negative), so a mode mix-up shows. The remaining cases are simultaneous updates to field 0, a compare to another field with a record in the same cycle, and overflow and clear raised together. These expose the priority order and the sticky bit's set-over-clear rule.

// File: rtl/cr_unit_pkg.sv
package cr_unit_pkg;
  localparam int FIELD_W = 4;

  typedef struct packed {
    logic so;
    logic eq;
    logic gt;
    logic lt;
  } crf_t;

  function automatic crf_t make_field(input logic lt, input logic gt,
                                      input logic eq, input logic so);
    crf_t f;
    f.lt = lt;
    f.gt = gt;
    f.eq = eq;
    f.so = so;
    return f;
  endfunction
endpackage

// File: rtl/cr_so_reg.sv
module cr_so_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ov_in,
  input  logic so_clear,
  output logic so_q,
  output logic so_next
);
  // set wins over clear; value is also what fields copy this cycle
  always_comb begin
    if (ov_in)         so_next = 1'b1;
    else if (so_clear) so_next = 1'b0;
    else               so_next = so_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) so_q <= 1'b0;
    else        so_q <= so_next;
  end
endmodule

// File: rtl/cr_field_eval.sv
module cr_field_eval
  import cr_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rec_result,
  input  logic              cmp_signed,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              stc_success,
  input  logic              so_val,
  output crf_t              rec_fld,
  output crf_t              cmp_fld,
  output crf_t              stc_fld
);
  logic rec_neg, rec_zero;
  logic cmp_lt, cmp_eq;

  always_comb begin
    rec_neg  = rec_result[DATA_W-1];
    rec_zero = (rec_result == '0);
    rec_fld  = make_field(rec_neg, !rec_neg && !rec_zero, rec_zero, so_val);
  end

  always_comb begin
    cmp_eq = (cmp_a == cmp_b);
    if (cmp_signed) cmp_lt = ($signed(cmp_a) < $signed(cmp_b));
    else            cmp_lt = (cmp_a < cmp_b);
    cmp_fld = make_field(cmp_lt, !cmp_lt && !cmp_eq, cmp_eq, so_val);
  end

  always_comb begin
    stc_fld = make_field(1'b0, 1'b0, stc_success, so_val);
  end
endmodule

// File: rtl/cr_field_bank.sv
module cr_field_bank
  import cr_unit_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int IDX_W      = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rec_valid,
  input  logic                          cmp_valid,
  input  logic [IDX_W-1:0]              cmp_field,
  input  logic                          stc_valid,
  input  crf_t                          rec_fld,
  input  crf_t                          cmp_fld,
  input  crf_t                          stc_fld,
  output logic [NUM_FIELDS*FIELD_W-1:0] cr_q
);
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_fld
    logic hit_cmp;
    crf_t cur, nxt;
    assign hit_cmp = cmp_valid && (cmp_field == IDX_W'(k));
    assign cur     = crf_t'(cr_q[k*FIELD_W +: FIELD_W]);

    if (k == 0) begin : g_primary
      // compare, then conditional store, then record
      always_comb begin
        if (hit_cmp)        nxt = cmp_fld;
        else if (stc_valid) nxt = stc_fld;
        else if (rec_valid) nxt = rec_fld;
        else                nxt = cur;
      end
    end else begin : g_other
      always_comb begin
        if (hit_cmp) nxt = cmp_fld;
        else         nxt = cur;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cr_q[k*FIELD_W +: FIELD_W] <= '0;
      else        cr_q[k*FIELD_W +: FIELD_W] <= nxt;
    end
  end
endmodule

// File: rtl/cr_unit.sv
module cr_unit
  import cr_unit_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int CR_W      = NUM_FIELDS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [DATA_W-1:0] rec_result,
  input  logic              cmp_valid,
  input  logic              cmp_signed,
  input  logic [IDX_W-1:0]  cmp_field,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              stc_valid,
  input  logic              stc_success,
  input  logic              ov_in,
  input  logic              so_clear,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [FIELD_W-1:0] rd_field,
  output logic [CR_W-1:0]   cr_out,
  output logic              so_out
);
  logic so_q, so_next;
  crf_t rec_fld, cmp_fld, stc_fld;

  cr_so_reg u_so (
    .clk      (clk),
    .rst_n    (rst_n),
    .ov_in    (ov_in),
    .so_clear (so_clear),
    .so_q     (so_q),
    .so_next  (so_next)
  );

  cr_field_eval #(.DATA_W(DATA_W)) u_eval (
    .rec_result  (rec_result),
    .cmp_signed  (cmp_signed),
    .cmp_a       (cmp_a),
    .cmp_b       (cmp_b),
    .stc_success (stc_success),
    .so_val      (so_next),
    .rec_fld     (rec_fld),
    .cmp_fld     (cmp_fld),
    .stc_fld     (stc_fld)
  );

  cr_field_bank #(.NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_valid (rec_valid),
    .cmp_valid (cmp_valid),
    .cmp_field (cmp_field),
    .stc_valid (stc_valid),
    .rec_fld   (rec_fld),
    .cmp_fld   (cmp_fld),
    .stc_fld   (stc_fld),
    .cr_q      (cr_out)
  );

  always_comb begin
    rd_field = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (rd_sel == IDX_W'(i)) rd_field = cr_out[i*FIELD_W +: FIELD_W];
  end

  assign so_out = so_q;
endmodule

// File: rtl/cr_unit_chk.sv
module cr_unit_chk #(
  parameter int NUM_FIELDS = 8,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int CR_W      = NUM_FIELDS * 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rec_valid,
  input logic              cmp_valid,
  input logic              cmp_signed,
  input logic [IDX_W-1:0]  cmp_field,
  input logic [DATA_W-1:0] cmp_a,
  input logic [DATA_W-1:0] cmp_b,
  input logic              stc_valid,
  input logic              stc_success,
  input logic              ov_in,
  input logic              so_clear,
  input logic [CR_W-1:0]   cr_out,
  input logic              so_out
);
  logic cmp_hits0;
  assign cmp_hits0 = cmp_valid && (cmp_field == '0);

  a_r3_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !cmp_hits0 && !stc_valid |=> $countones(cr_out[2:0]) == 1);

  a_r5_stc_flags: assert property (@(posedge clk) disable iff (!rst_n)
    stc_valid && !cmp_hits0 |=> cr_out[1:0] == 2'b00 && cr_out[2] == $past(stc_success));

  a_r6_so_set: assert property (@(posedge clk) disable iff (!rst_n)
    ov_in |=> so_out);

  a_r6_so_hold: assert property (@(posedge clk) disable iff (!rst_n)
    so_out && !so_clear |=> so_out);

  a_r6_so_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !so_out && !ov_in |=> !so_out);

  a_r7_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid || stc_valid || cmp_hits0 |=> cr_out[3] == so_out);

  a_r8_cmp_first: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hits0 && !cmp_signed && cmp_a == cmp_b |=> cr_out[2:0] == 3'b100);

  for (genvar k = 1; k < NUM_FIELDS; k++) begin : g_hold
    a_r9_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmp_valid && cmp_field == IDX_W'(k)) |=> $stable(cr_out[k*4 +: 4]));
  end
endmodule

bind cr_unit cr_unit_chk #(.NUM_FIELDS(NUM_FIELDS), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rec_valid   (rec_valid),
  .cmp_valid   (cmp_valid),
  .cmp_signed  (cmp_signed),
  .cmp_field   (cmp_field),
  .cmp_a       (cmp_a),
  .cmp_b       (cmp_b),
  .stc_valid   (stc_valid),
  .stc_success (stc_success),
  .ov_in       (ov_in),
  .so_clear    (so_clear),
  .cr_out      (cr_out),
  .so_out      (so_out)
);

// File: tb/sim_cr_unit.sv
`timescale 1ns/1ps
module sim_cr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rec_valid, cmp_valid, cmp_signed, stc_valid, stc_success, ov_in, so_clear;
  logic [31:0] rec_result, cmp_a, cmp_b, cr_out;
  logic [2:0]  cmp_field, rd_sel;
  logic [3:0]  rd_field;
  logic        so_out;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  cr_unit u0 (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_result(rec_result),
    .cmp_valid(cmp_valid), .cmp_signed(cmp_signed), .cmp_field(cmp_field),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .stc_valid(stc_valid), .stc_success(stc_success),
    .ov_in(ov_in), .so_clear(so_clear), .rd_sel(rd_sel), .rd_field(rd_field),
    .cr_out(cr_out), .so_out(so_out)
  );

  // {kind(2): 0 rec,1 cmp,2 stc ; field(3) ; signed(1) ; a(32) ; b(32) ; expected nibble(4)}
  localparam int VW = 74;
  localparam int NV = 10;
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 3'd0, 1'b0, 32'd5,          32'd0,          4'b0010},
    {2'd0, 3'd0, 1'b0, 32'd0,          32'd0,          4'b0100},
    {2'd0, 3'd0, 1'b0, 32'h8000_0000,  32'd0,          4'b0001},
    {2'd1, 3'd3, 1'b1, 32'hFFFF_FFFF,  32'd1,          4'b0001},
    {2'd1, 3'd3, 1'b0, 32'hFFFF_FFFF,  32'd1,          4'b0010},
    {2'd1, 3'd7, 1'b1, 32'd7,          32'd7,          4'b0100},
    {2'd1, 3'd5, 1'b0, 32'd0,          32'd1,          4'b0001},
    {2'd2, 3'd0, 1'b0, 32'd1,          32'd0,          4'b0100},
    {2'd2, 3'd0, 1'b0, 32'd0,          32'd0,          4'b0000},
    {2'd1, 3'd1, 1'b1, 32'h7FFF_FFFF,  32'h8000_0000,  4'b0010}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rec_valid = 0; cmp_valid = 0; stc_valid = 0; ov_in = 0; so_clear = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    rec_result = 0; cmp_signed = 0; cmp_field = 0; cmp_a = 0; cmp_b = 0;
    stc_success = 0; rd_sel = 0; rst_n = 0;
    step(); step();
    check("R1 cr", cr_out, 32'h0);
    check("R1 so", {31'd0, so_out}, 32'd0);
    rst_n = 1;

    // R3 R4 R5 R2 via table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      logic [2:0] fld;
      logic [3:0] expn;
      kind = VEC[i][73:72];
      fld  = VEC[i][71:69];
      expn = VEC[i][3:0];
      rd_sel = fld;
      case (kind)
        2'd0: begin rec_valid = 1; rec_result = VEC[i][67:36]; end
        2'd1: begin cmp_valid = 1; cmp_field = fld; cmp_signed = VEC[i][68];
                    cmp_a = VEC[i][67:36]; cmp_b = VEC[i][35:4]; end
        default: begin stc_valid = 1; stc_success = VEC[i][36]; end
      endcase
      step();
      idle();
      check($sformatf("R3/R4/R5 vec%0d rd_field", i), {28'd0, rd_field}, {28'd0, expn});
      check($sformatf("R2 vec%0d cr_out slice", i), {28'd0, cr_out[fld*4 +: 4]}, {28'd0, expn});
    end
    check("R9 untouched fields", cr_out, 32'h4010_2020);

    // R9: operands with valid low have no effect
    cmp_field = 3'd3; cmp_a = 0; cmp_b = 1; cmp_signed = 0; rec_result = 32'hFFFF_FFFF;
    step();
    check("R9 valid low", cr_out, 32'h4010_2020);

    // R6 R7: overflow sets SO and is copied
    rec_valid = 1; rec_result = 32'd3; ov_in = 1;
    step(); idle();
    check("R7 field0 with SO", {28'd0, cr_out[3:0]}, 32'hA);
    check("R6 so set", {31'd0, so_out}, 32'd1);
    cmp_valid = 1; cmp_field = 3'd2; cmp_signed = 1; cmp_a = 1; cmp_b = 1;
    step(); idle();
    check("R7 sticky copied", {28'd0, cr_out[11:8]}, 32'hC);
    step();
    check("R6 sticky hold", {31'd0, so_out}, 32'd1);
    so_clear = 1; cmp_valid = 1; cmp_field = 3'd4; cmp_signed = 0; cmp_a = 2; cmp_b = 1;
    step(); idle();
    check("R7 cleared value copied", {28'd0, cr_out[19:16]}, 32'h2);
    check("R6 so cleared", {31'd0, so_out}, 32'd0);
    so_clear = 1; ov_in = 1;
    step(); idle();
    check("R6 set beats clear", {31'd0, so_out}, 32'd1);
    so_clear = 1;
    step(); idle();
    check("R6 clear alone", {31'd0, so_out}, 32'd0);

    // R8 priorities on field 0
    cmp_valid = 1; cmp_field = 3'd0; cmp_signed = 1; cmp_a = 1; cmp_b = 2;
    stc_valid = 1; stc_success = 1; rec_valid = 1; rec_result = 5;
    step(); idle();
    check("R8 compare wins", {28'd0, cr_out[3:0]}, 32'h1);
    stc_valid = 1; stc_success = 1; rec_valid = 1; rec_result = 5;
    step(); idle();
    check("R8 store over record", {28'd0, cr_out[3:0]}, 32'h4);
    cmp_valid = 1; cmp_field = 3'd6; cmp_signed = 0; cmp_a = 9; cmp_b = 3;
    rec_valid = 1; rec_result = 32'hFFFF_FFF0;
    step(); idle();
    check("R8 both other field", {28'd0, cr_out[27:24]}, 32'h2);
    check("R8 both field0", {28'd0, cr_out[3:0]}, 32'h1);

    // R10 read port and latency
    rd_sel = 3'd2; #1;
    check("R10 read f2", {28'd0, rd_field}, 32'hC);
    rd_sel = 3'd6; #1;
    check("R10 read f6", {28'd0, rd_field}, 32'h2);
    rd_sel = 3'd5;
    cmp_valid = 1; cmp_field = 3'd5; cmp_signed = 1; cmp_a = 4; cmp_b = 4;
    #1;
    check("R10 before edge", {28'd0, rd_field}, 32'h1);
    step(); idle();
    check("R10 after edge", {28'd0, rd_field}, 32'h4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule